// File: doc/BRIEF.md
# Run-Time Programmable Third-Order Decimator for a One-Bit Bitstream

This block turns the one-bit output of a sigma-delta modulator into 24-bit conversion results. Each modulator bit arrives with a one-cycle enable. In a typical system the enable comes once every 128 clocks of the master clock. The bit is read as +1 or -1 and goes into a chain of three integrators. A decimation counter picks out one integrator sample per output period. Three comb stages then difference that sample against the one from the previous period. The result is a third-order sinc response whose first notch sits at the output rate.

The output period is set at run time by an 11-bit rate code: each output covers four times the code in modulator bits. Codes from 10 up are accepted, and smaller codes are ignored. The comb result is normalised to 24 bits by a shift that depends on the code, and a parameter reserves headroom above full scale. The result is then clamped and delivered in offset binary, so mid-scale is 800000h.

Loading a new code or pulsing the sync input clears the whole datapath. The first three outputs after any clear are withheld, so the first flagged result already has a fully settled filter window.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` is 0 and `out_data` is 800000h. The rate code resets to `CODE_DEF`.
- R2: Input bit 1 counts as +1 and bit 0 counts as -1. An output is produced once per 4*code accepted bits. Before scaling, its value is the sum of the accepted bits since the last clear, weighted by a length-4*code rectangular window convolved with itself three times. Bits from before the clear count as zero.
- R3: A load with a code below `CODE_MIN` (10) is ignored. The ratio, the counter phase and the settle state are kept, and outputs continue without interruption.
- R4: A load with an accepted code, or a high `sync_clr`, clears the integrators, combs, counter and settle state on that edge, and drops any bit offered on that edge. Of the output periods that follow, the first three are not flagged and the fourth is.
- R5: With L = ceil(log2(4*code)) and T = 23 - `HEAD_BITS`, the comb result is shifted arithmetically right by 3L-T. When 3L-T is negative, it is shifted left by T-3L instead.
- R6: The shifted value is clamped to the signed 24-bit range, and its MSB is inverted to give offset binary. A zero-mean input gives 800000h, the most negative value gives 000000h, and overflow gives FFFFFFh.
- R7: `out_valid` is a single-cycle pulse. `out_data` changes only in a cycle where `out_valid` is high, and holds its value otherwise.
- R8: `out_valid` goes high after the second rising edge that follows the edge which accepts the last bit of a period.
- R9: While `mod_en` is low, `mod_bit` has no effect and the decimation counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator bit strobe |
| mod_bit | input | 1 | Modulator bit |
| rate_load | input | 1 | Write strobe for the rate code |
| rate_code | input | 11 | Rate code, output period = 4*code bits |
| sync_clr | input | 1 | Clears the datapath and restarts settling |
| out_data | output | 24 | Offset-binary result |
| out_valid | output | 1 | One-cycle data-ready pulse |

## Verification
The bench builds the block with `HEAD_BITS` set to 0. This puts a constant all-ones input at a power-of-two ratio exactly at the positive clamp, and an all-zeros input exactly at the negative code. Ratios of 40, 44, 64 and 8188 cover both the left-shift and the right-shift paths of the normalisation, including the widest 40-bit comb values. The reference model is built from three running window sums held in queues, and it is compared with the outputs on every clock. Random idle gaps in the strobe pattern test that the counter and integrators hold still.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  // smallest k with 2**k >= v (v >= 1)
  function automatic int ceil_lg(input int v);
    int r;
    r = 0;
    for (int i = 30; i >= 0; i--) begin
      if ((32'sd1 <<< i) >= v) r = i;
    end
    return r;
  endfunction

  // signed normalisation shift: positive means right shift
  function automatic int norm_shift(input int code, input int n_stage, input int tgt);
    return n_stage * ceil_lg(4 * code) - tgt;
  endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int CODE_W   = 11,
  parameter int CODE_MIN = 10,
  parameter int CODE_DEF = 10,
  parameter int N_STAGE  = 3,
  parameter int TGT      = 22,
  parameter int SH_W     = 7,
  parameter int SETTLE   = 3,
  localparam int CNT_W   = CODE_W + 2,
  localparam int PER_W   = $clog2(SETTLE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              rate_load,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              sync_clr,
  output logic              clr,
  output logic              tick_q,
  output logic              flag_q,
  output logic [CODE_W-1:0] code_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [SH_W-1:0]   shr_q,
  output logic [SH_W-1:0]   shl_q
);

  localparam int SA_DEF = norm_shift(CODE_DEF, N_STAGE, TGT);
  localparam logic [SH_W-1:0] SHR_DEF = (SA_DEF >= 0) ? SH_W'(SA_DEF) : '0;
  localparam logic [SH_W-1:0] SHL_DEF = (SA_DEF < 0) ? SH_W'(-SA_DEF) : '0;

  logic               load_ok;
  logic [CNT_W-1:0]   last_cnt;
  logic [PER_W-1:0]   per_q;
  int                 sa_new;
  logic [SH_W-1:0]    shr_new;
  logic [SH_W-1:0]    shl_new;

  assign load_ok  = rate_load && (rate_code >= CODE_W'(CODE_MIN));
  assign clr      = sync_clr || load_ok;
  assign last_cnt = {code_q, 2'b00} - CNT_W'(1);

  always_comb begin
    sa_new  = norm_shift(int'(rate_code), N_STAGE, TGT);
    shr_new = (sa_new >= 0) ? SH_W'(sa_new) : '0;
    shl_new = (sa_new < 0) ? SH_W'(-sa_new) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_W'(CODE_DEF);
      shr_q  <= SHR_DEF;
      shl_q  <= SHL_DEF;
      cnt_q  <= '0;
      per_q  <= '0;
      tick_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      flag_q <= 1'b0;
      if (load_ok) begin
        code_q <= rate_code;
        shr_q  <= shr_new;
        shl_q  <= shl_new;
      end
      if (clr) begin
        cnt_q <= '0;
        per_q <= '0;
      end else if (mod_en) begin
        if (cnt_q == last_cnt) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
          flag_q <= (per_q == PER_W'(SETTLE));
          if (per_q != PER_W'(SETTLE)) per_q <= per_q + PER_W'(1);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int W = 40,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic                bit_in,
  output logic signed [W-1:0] acc_out
);

  logic signed [W-1:0] acc [N];
  logic signed [W-1:0] nxt [N];
  logic signed [W-1:0] x_in;

  // bit 1 -> +1, bit 0 -> -1
  assign x_in = {{(W-1){~bit_in}}, 1'b1};

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign nxt[g] = acc[g] + x_in;
    end else begin : g_rest
      assign nxt[g] = acc[g] + nxt[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) acc[g] <= '0;
      else if (en)    acc[g] <= nxt[g];
    end
  end

  assign acc_out = acc[N-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int W = 40,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic                flag_in,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic                vld,
  output logic                flag_out
);

  logic signed [W-1:0] dly [N];
  logic signed [W-1:0] sin [N+1];

  assign sin[0] = din;

  for (genvar g = 0; g < N; g++) begin : g_stage
    assign sin[g+1] = sin[g] - dly[g];
    always_ff @(posedge clk) begin
      if (rst || clr) dly[g] <= '0;
      else if (en)    dly[g] <= sin[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dout     <= '0;
      vld      <= 1'b0;
      flag_out <= 1'b0;
    end else begin
      vld      <= en;
      flag_out <= en && flag_in;
      if (en) dout <= sin[N];
    end
  end

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int W     = 40,
  parameter int OUT_W = 24,
  parameter int SH_W  = 7
) (
  input  logic signed [W-1:0] din,
  input  logic [SH_W-1:0]     shr,
  input  logic [SH_W-1:0]     shl,
  output logic [OUT_W-1:0]    dout
);

  localparam logic signed [W-1:0] POS_MAX = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [W-1:0] NEG_MIN = -POS_MAX - W'(1);

  logic signed [W-1:0] sh;

  always_comb begin
    if (shl != '0) sh = din <<< shl;
    else           sh = din >>> shr;

    if (sh > POS_MAX)      dout = {1'b1, {(OUT_W-1){1'b1}}};
    else if (sh < NEG_MIN) dout = '0;
    else                   dout = {~sh[OUT_W-1], sh[OUT_W-2:0]};
  end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int ACC_W     = 40,
  parameter int OUT_W     = 24,
  parameter int CODE_W    = 11,
  parameter int CODE_MIN  = 10,
  parameter int CODE_DEF  = 10,
  parameter int HEAD_BITS = 1,
  parameter int N_STAGE   = 3,
  parameter int SETTLE    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              mod_bit,
  input  logic              rate_load,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              sync_clr,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid
);

  localparam int TGT   = OUT_W - 1 - HEAD_BITS;
  localparam int SH_W  = $clog2(ACC_W) + 1;
  localparam int CNT_W = CODE_W + 2;
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  logic                    clr;
  logic                    tick_q;
  logic                    flag_q;
  logic [CODE_W-1:0]       code_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [SH_W-1:0]         shr_q;
  logic [SH_W-1:0]         shl_q;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;
  logic                    comb_vld;
  logic                    comb_flag;
  logic [OUT_W-1:0]        scaled;

  sinc3_ctrl #(
    .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_DEF(CODE_DEF),
    .N_STAGE(N_STAGE), .TGT(TGT), .SH_W(SH_W), .SETTLE(SETTLE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mod_en(mod_en), .rate_load(rate_load),
    .rate_code(rate_code), .sync_clr(sync_clr), .clr(clr),
    .tick_q(tick_q), .flag_q(flag_q), .code_q(code_q), .cnt_q(cnt_q),
    .shr_q(shr_q), .shl_q(shl_q)
  );

  sinc3_integ #(.W(ACC_W), .N(N_STAGE)) u_integ (
    .clk(clk), .rst(rst), .clr(clr), .en(mod_en), .bit_in(mod_bit),
    .acc_out(integ_out)
  );

  sinc3_comb #(.W(ACC_W), .N(N_STAGE)) u_comb (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_q), .flag_in(flag_q),
    .din(integ_out), .dout(comb_out), .vld(comb_vld), .flag_out(comb_flag)
  );

  sinc3_scale #(.W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
    .din(comb_out), .shr(shr_q), .shl(shl_q), .dout(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= MID;
    end else begin
      out_valid <= 1'b0;
      if (comb_vld && comb_flag && !clr) begin
        out_valid <= 1'b1;
        out_data  <= scaled;
      end
    end
  end

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int CODE_W   = 11,
  parameter int CODE_MIN = 10,
  parameter int OUT_W    = 24,
  localparam int CNT_W   = CODE_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mod_en,
  input logic              rate_load,
  input logic [CODE_W-1:0] rate_code,
  input logic              sync_clr,
  input logic [CODE_W-1:0] code_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_valid
);

  logic good_load;
  assign good_load = rate_load && (rate_code >= CODE_W'(CODE_MIN));

  // R7
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R4
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_clr || good_load) |=> !out_valid);

  // R3
  code_floor_chk: assert property (@(posedge clk) disable iff (rst)
    code_q >= CODE_W'(CODE_MIN));

  // R3
  bad_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_load && !good_load) |=> $stable(code_q));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(mod_en, 3));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && !sync_clr && !rate_load) |=> $stable(cnt_q));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < {code_q, 2'b00});

endmodule

bind sinc3_decim sinc3_decim_chk #(
  .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .mod_en(mod_en), .rate_load(rate_load),
  .rate_code(rate_code), .sync_clr(sync_clr), .code_q(code_q),
  .cnt_q(cnt_q), .out_data(out_data), .out_valid(out_valid)
);

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

  localparam int HEAD_BITS = 0;
  localparam int CODE_DEF  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_en = 1'b0;
  logic        mod_bit = 1'b0;
  logic        rate_load = 1'b0;
  logic [10:0] rate_code = '0;
  logic        sync_clr = 1'b0;
  logic [23:0] out_data;
  logic        out_valid;

  always #5 clk = ~clk;

  sinc3_decim #(.HEAD_BITS(HEAD_BITS), .CODE_DEF(CODE_DEF)) u0 (
    .clk(clk), .rst(rst), .mod_en(mod_en), .mod_bit(mod_bit),
    .rate_load(rate_load), .rate_code(rate_code), .sync_clr(sync_clr),
    .out_data(out_data), .out_valid(out_valid)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  string       tag = "R1";
  int unsigned lcg = 32'h1234_5678;

  // reference model: three running window sums
  longint      q1[$], q2[$], q3[$];
  longint      s1, s2, s3;
  int          nsamp, per, cur_code;
  bit          pv[3];
  logic [23:0] pd[3];
  logic [23:0] hold = 24'h800000;
  int          pulses = 0;

  function automatic logic [23:0] scale_ref(input longint y, input int code);
    int L, tot, tgt;
    longint sc;
    L = $clog2(4 * code);
    tot = 3 * L;
    tgt = 23 - HEAD_BITS;
    if (tot >= tgt) sc = y >>> (tot - tgt);
    else            sc = y <<< (tgt - tot);
    if (sc > 64'sd8388607)  sc = 64'sd8388607;
    if (sc < -64'sd8388608) sc = -64'sd8388608;
    return 24'(sc + 64'sd8388608);
  endfunction

  function automatic void model_clear();
    q1.delete(); q2.delete(); q3.delete();
    s1 = 0; s2 = 0; s3 = 0;
    nsamp = 0; per = 0;
  endfunction

  function automatic void model_sample(input logic b);
    longint x;
    int r;
    r = 4 * cur_code;
    x = b ? 64'sd1 : -64'sd1;
    q1.push_back(x);  s1 += x;  if (q1.size() > r) s1 -= q1.pop_front();
    q2.push_back(s1); s2 += s1; if (q2.size() > r) s2 -= q2.pop_front();
    q3.push_back(s2); s3 += s2; if (q3.size() > r) s3 -= q3.pop_front();
    nsamp++;
    if (nsamp % r == 0) begin
      per++;
      if (per >= 4) begin
        pv[0] = 1'b1;
        pd[0] = scale_ref(s3, cur_code);
      end
    end
  endfunction

  function automatic logic next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic step(input logic en, input logic b, input logic ld,
                      input logic [10:0] cd, input logic sy);
    bit ev;
    @(negedge clk);
    ev = pv[2];
    if (ev) hold = pd[2];
    n_chk++;
    if (out_valid !== ev || out_data !== hold) begin
      n_bad++;
      $display("FAIL %s/R7/R8 cycle compare: valid %0b data %h, expected valid %0b data %h",
               tag, out_valid, out_data, ev, hold);
    end
    if (out_valid === 1'b1) pulses++;
    pv[2] = pv[1]; pd[2] = pd[1];
    pv[1] = pv[0]; pd[1] = pd[0];
    pv[0] = 1'b0;  pd[0] = '0;
    mod_en = en; mod_bit = b; rate_load = ld; rate_code = cd; sync_clr = sy;
    if (!rst) begin
      if (sy || (ld && cd >= 11'd10)) begin
        model_clear();
        if (ld && cd >= 11'd10) cur_code = int'(cd);
        pv[1] = 1'b0;
        pv[2] = 1'b0;
      end else if (en) begin
        model_sample(b);
      end
    end
  endtask

  // mode: 0 random, 1 all ones, 2 all zeros, 3 alternating
  task automatic run_periods(input int np, input int mode);
    int total;
    logic b;
    total = np * 4 * cur_code;
    for (int k = 0; k < total; k++) begin
      case (mode)
        0:       b = next_rand();
        1:       b = 1'b1;
        2:       b = 1'b0;
        default: b = k[0];
      endcase
      step(1'b1, b, 1'b0, 11'd0, 1'b0);
      step(1'b0, next_rand(), 1'b0, 11'd0, 1'b0);
      if (lcg[20:18] == 3'd0) step(1'b0, next_rand(), 1'b0, 11'd0, 1'b0);
    end
    repeat (4) step(1'b0, 1'b0, 1'b0, 11'd0, 1'b0);
  endtask

  initial begin
    logic [23:0] d0;
    int p0;
    cur_code = CODE_DEF;
    model_clear();
    pv = '{default: 1'b0};
    pd = '{default: '0};

    // R1 reset state
    tag = "R1";
    repeat (3) step(1'b0, 1'b0, 1'b0, 11'd0, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 11'd0, 1'b0);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_data == 24'h800000, "R1 data after reset", out_data, 24'h800000);

    // R2 random bits at the default ratio, first three periods held back
    tag = "R2";
    pulses = 0;
    run_periods(13, 0);
    chk(pulses == 10, "R2 output count", pulses, 10);

    // R3 codes below the floor are ignored
    tag = "R3";
    step(1'b0, 1'b0, 1'b1, 11'd5, 1'b0);
    step(1'b0, 1'b0, 1'b1, 11'd0, 1'b0);
    pulses = 0;
    run_periods(8, 0);
    chk(pulses == 8, "R3 no settle after ignored code", pulses, 8);

    // R4 sync clears, alternating bits give mid-scale (R6)
    tag = "R4";
    step(1'b0, 1'b0, 1'b0, 11'd0, 1'b1);
    pulses = 0;
    run_periods(6, 3);
    chk(pulses == 3, "R4 settle after sync", pulses, 3);
    chk(out_data == 24'h800000, "R6 zero-mean code", out_data, 24'h800000);

    // R9 bits without strobe change nothing
    tag = "R9";
    d0 = out_data;
    p0 = pulses;
    repeat (40) step(1'b0, next_rand(), 1'b0, 11'd0, 1'b0);
    chk(out_data == d0, "R9 data unchanged while idle", out_data, d0);
    chk(pulses == p0, "R9 no output while idle", pulses, p0);

    // R6 clamp at a power-of-two ratio
    tag = "R6";
    step(1'b0, 1'b0, 1'b1, 11'd16, 1'b0);
    pulses = 0;
    run_periods(6, 1);
    chk(pulses == 3, "R4 settle after code load", pulses, 3);
    chk(out_data == 24'hFFFFFF, "R6 positive clamp", out_data, 24'hFFFFFF);
    run_periods(6, 2);
    chk(out_data == 24'h000000, "R6 negative full scale", out_data, 24'h000000);

    // R5 left shift at ratio 44, right shift at ratio 8188
    tag = "R5";
    step(1'b0, 1'b0, 1'b1, 11'd11, 1'b0);
    pulses = 0;
    run_periods(8, 0);
    chk(pulses == 5, "R5 outputs at ratio 44", pulses, 5);
    step(1'b0, 1'b0, 1'b1, 11'd2047, 1'b0);
    pulses = 0;
    run_periods(4, 0);
    chk(pulses == 1, "R5 outputs at ratio 8188", pulses, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule